// File: doc/BRIEF.md
# ATA Task-File I/O Decoder

This block is the host-facing register port of a storage card operating in contiguous I/O mode. Each host access is described by an I/O-space select, four address bits, two active-low chip enables (low lane and high lane) and active-low read and write strobes. The strobes are sampled by the block clock. An access takes effect once, in the first clock cycle in which a strobe is seen low after being high. The block decodes the access and routes it to one of three places: a task-file register, the status logic, or a 512-byte sector buffer that is reached through a byte pointer.

The sector buffer can be reached at offsets 0, 8 and 9, and the chip-enable pattern sets the access width. With both enables low, an access is a 16-bit word. With only the low-lane enable low, it is a byte on D7..D0. With only the high-lane enable low, it is a byte on D15..D8 at the odd neighbour of the given offset. Byte accesses walk the buffer even byte first, then odd byte. A byte access to offset 9 moves only the odd byte, so the order 9 then 8 transfers odd then even and ends one word further on.

The block holds no command engine. It presents the stored features and command bytes to the logic behind it. It raises an interrupt flag on each command write.

Top module: `ata_taskfile_io`

## Requirements
- R1: After reset the buffer pointer is 0, the sector count and sector number read 0x01, the cylinder and card/head registers read 0x00, intrq is 0, d_oe is 0 and status reads 0x48.
- R2: Offsets 2 to 6 (sector count, sector number, cylinder low, cylinder high, card/head) are read/write bytes. With only ce1_n low the byte is on d[7:0]. With only ce2_n low the access reaches offset addr|1 on d[15:8].
- R3: With both enables low at offset 0, 1, 8 or 9, one buffer word moves: the even byte is on d[7:0] and the odd byte on d[15:8]. The pointer advances by 2.
- R4: Byte accesses with only ce1_n low to offset 0 or 8, in any mix, move consecutive buffer bytes on d[7:0]. Each one advances the pointer by 1.
- R5: A byte access with only ce2_n low at offset 0 reads the error register (0x00 on d[15:8]) or writes the features byte (shown on cmd_features). It leaves the buffer pointer unchanged.
- R6: At an even pointer, a byte access to offset 9 moves the odd byte of the current word and leaves the pointer in place. A following access at 0 or 8 then moves the even byte and advances by 2, so 8,9 and 9,8 each cover one word.
- R7: A word data access while the pointer is odd is ignored: d_oe stays 0, nothing is written and the pointer is unchanged.
- R8: Writing offset 7 stores the command, sets intrq and returns the pointer to 0. Reading offset 7 (status) clears intrq. Reading offset E (alternate status) returns the same byte and leaves intrq set.
- R9: A write to offset E with bit 2 set returns the pointer to 0 and clears intrq. The same write with bit 2 clear changes neither.
- R10: Status bit 3 (data request) is 1 while the pointer is below 512, giving 0x48, and 0 once 512 bytes have moved, giving 0x40. Data accesses at pointer 512 are ignored.
- R11: An access with io_sel_n high, with both enables high, or to offsets A to C is ignored, as is a write to offset F. Ignored means no bus drive and no state change. Reading offset F returns {2'b11, ~cardhead[3:0], 2'b10}.
- R12: Holding a strobe low for several cycles performs one access. A cycle with both strobes low performs none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel_n | input | 1 | Low selects the task-file I/O space |
| addr | input | 4 | Register offset |
| ce1_n | input | 1 | Low-lane chip enable, active low |
| ce2_n | input | 1 | High-lane chip enable, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| d_in | input | 16 | Host write data |
| d_out | output | 16 | Read data, zero when not driven |
| d_oe | output | 1 | Read data drive enable |
| intrq | output | 1 | Pending interrupt flag |
| cmd_features | output | 8 | Last written features byte |
| cmd_opcode | output | 8 | Last written command byte |

## Verification
The assertions assume that a strobe pulse is never overlapped by the other strobe. They also assume that address, enables and write data stay steady from the first low cycle of a strobe until it is released, so each decoded event belongs to one host access. The bench drives every access from a single task. That task sets the whole access on a falling clock edge, holds it for one full cycle and releases everything together. Only the one scenario that is meant to test overlapping strobes breaks this rule, and it does so deliberately.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  typedef enum logic [1:0] {
    XF_NONE,
    XF_WORD,
    XF_BYTE_SEQ,
    XF_BYTE_ODD
  } xfer_e;

  typedef struct packed {
    logic       hit;
    xfer_e      xf;
    logic [3:0] off;
    logic       lane_hi;
  } acc_t;

  // Pointer advance for one data transfer.
  function automatic logic [1:0] ptr_step(xfer_e xf, logic ptr_odd, logic odd_done);
    case (xf)
      XF_WORD:     return 2'd2;
      XF_BYTE_SEQ: return (!ptr_odd && odd_done) ? 2'd2 : 2'd1;
      XF_BYTE_ODD: return ptr_odd ? 2'd1 : 2'd0;
      default:     return 2'd0;
    endcase
  endfunction

  // Byte offset from the pointer used by a byte transfer.
  function automatic logic byte_off(xfer_e xf, logic ptr_odd);
    return (xf == XF_BYTE_ODD) && !ptr_odd;
  endfunction

  function automatic logic odd_next(xfer_e xf, logic ptr_odd);
    return (xf == XF_BYTE_ODD) && !ptr_odd;
  endfunction

  function automatic logic [7:0] status_byte(logic drq);
    return {1'b0, 1'b1, 2'b00, drq, 3'b000};
  endfunction

  function automatic logic [7:0] drive_addr(logic [7:0] cardhead);
    return {2'b11, ~cardhead[3:0], 2'b10};
  endfunction

endpackage

// File: rtl/tf_decode.sv
module tf_decode
  import ata_tf_pkg::*;
(
  input  logic       io_sel_n,
  input  logic [3:0] addr,
  input  logic       ce1_n,
  input  logic       ce2_n,
  input  logic       is_wr,
  output acc_t       acc
);

  logic any_en;
  logic word_en;
  logic dat_word;

  always_comb begin
    any_en   = !io_sel_n && (!ce1_n || !ce2_n);
    word_en  = !ce1_n && !ce2_n;
    dat_word = word_en && (addr[2:1] == 2'b00) && (addr[3] ? 1'b1 : 1'b1)
               && ((addr[3:1] == 3'b000) || (addr[3:1] == 3'b100));
    acc         = '0;
    acc.xf      = XF_NONE;
    acc.lane_hi = ce1_n;
    acc.off     = ce1_n ? (addr | 4'h1) : addr;
    if (dat_word) begin
      acc.xf      = XF_WORD;
      acc.off     = {addr[3], 3'b000};
      acc.lane_hi = 1'b0;
    end else begin
      case (acc.off)
        4'h0, 4'h8: acc.xf = XF_BYTE_SEQ;
        4'h9:       acc.xf = XF_BYTE_ODD;
        default:    acc.xf = XF_NONE;
      endcase
    end
    acc.hit = any_en
              && !(acc.off inside {4'hA, 4'hB, 4'hC})
              && !(is_wr && acc.off == 4'hF);
  end

endmodule

// File: rtl/tf_databuf.sv
module tf_databuf
  import ata_tf_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          we,
  input  xfer_e         xf,
  input  logic [15:0]   wword,
  input  logic [7:0]    wbyte,
  input  logic          clr,
  output logic [PW-1:0] ptr,
  output logic [15:0]   rword,
  output logic [7:0]    rbyte
);

  logic [7:0]    mem [BUF_BYTES];
  logic          odd_done;
  logic [AW-1:0] ia_even;
  logic [AW-1:0] ia_odd;
  logic [AW-1:0] ib;

  always_comb begin
    ia_even = {ptr[AW-1:1], 1'b0};
    ia_odd  = {ptr[AW-1:1], 1'b1};
    ib      = ptr[AW-1:0] + AW'(byte_off(xf, ptr[0]));
    rword   = {mem[ia_odd], mem[ia_even]};
    rbyte   = mem[ib];
  end

  always_ff @(posedge clk) begin
    if (go && we) begin
      if (xf == XF_WORD) begin
        mem[ia_even] <= wword[7:0];
        mem[ia_odd]  <= wword[15:8];
      end else begin
        mem[ib] <= wbyte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      odd_done <= 1'b0;
    end else if (clr) begin
      ptr      <= '0;
      odd_done <= 1'b0;
    end else if (go) begin
      ptr      <= ptr + PW'(ptr_step(xf, ptr[0], odd_done));
      odd_done <= odd_next(xf, ptr[0]);
    end
  end

endmodule

// File: rtl/tf_regs.sv
module tf_regs
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_go,
  input  logic [3:0] off,
  input  logic [7:0] wbyte,
  input  logic       drq,
  input  logic       stat_rd,
  input  logic       srst,
  output logic [7:0] rbyte,
  output logic       intrq,
  output logic [7:0] features,
  output logic [7:0] opcode
);

  logic [7:0] sec_cnt, sec_num, cyl_lo, cyl_hi, cardhead;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_cnt  <= 8'h01;
      sec_num  <= 8'h01;
      cyl_lo   <= 8'h00;
      cyl_hi   <= 8'h00;
      cardhead <= 8'h00;
      features <= 8'h00;
      opcode   <= 8'h00;
      intrq    <= 1'b0;
    end else begin
      if (wr_go) begin
        case (off)
          4'h1, 4'hD: features <= wbyte;
          4'h2:       sec_cnt  <= wbyte;
          4'h3:       sec_num  <= wbyte;
          4'h4:       cyl_lo   <= wbyte;
          4'h5:       cyl_hi   <= wbyte;
          4'h6:       cardhead <= wbyte;
          4'h7:       opcode   <= wbyte;
          default:    ;
        endcase
      end
      if (wr_go && off == 4'h7) intrq <= 1'b1;
      else if (stat_rd || srst) intrq <= 1'b0;
    end
  end

  always_comb begin
    case (off)
      4'h2:       rbyte = sec_cnt;
      4'h3:       rbyte = sec_num;
      4'h4:       rbyte = cyl_lo;
      4'h5:       rbyte = cyl_hi;
      4'h6:       rbyte = cardhead;
      4'h7, 4'hE: rbyte = status_byte(drq);
      4'hF:       rbyte = drive_addr(cardhead);
      default:    rbyte = 8'h00;
    endcase
  end

endmodule

// File: rtl/ata_taskfile_io.sv
module ata_taskfile_io
  import ata_tf_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int PW = AW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_sel_n,
  input  logic [3:0]  addr,
  input  logic        ce1_n,
  input  logic        ce2_n,
  input  logic        iord_n,
  input  logic        iowr_n,
  input  logic [15:0] d_in,
  output logic [15:0] d_out,
  output logic        d_oe,
  output logic        intrq,
  output logic [7:0]  cmd_features,
  output logic [7:0]  cmd_opcode
);

  acc_t          acc;
  logic          rd_q, wr_q;
  logic          rd_start, wr_start;
  logic          is_dat, dat_ok;
  logic          data_go, word_go, seq_go;
  logic          reg_wr, cmd_wr, srst_ev, stat_rd, ptr_clr;
  logic          rd_ok, drq;
  logic [7:0]    wbyte, reg_byte, dat_byte, sel_byte;
  logic [15:0]   dat_word, rval, rdata_q;
  logic          rd_act_q;
  logic [PW-1:0] ptr;

  tf_decode u_dec (
    .io_sel_n (io_sel_n),
    .addr     (addr),
    .ce1_n    (ce1_n),
    .ce2_n    (ce2_n),
    .is_wr    (!iowr_n),
    .acc      (acc)
  );

  always_comb begin
    rd_start = !iord_n && rd_q && iowr_n;
    wr_start = !iowr_n && wr_q && iord_n;
    wbyte    = acc.lane_hi ? d_in[15:8] : d_in[7:0];
    is_dat   = acc.xf != XF_NONE;
    drq      = ptr < PW'(BUF_BYTES);
    dat_ok   = drq && !(acc.xf == XF_WORD && ptr[0]);
    data_go  = (rd_start || wr_start) && acc.hit && is_dat && dat_ok;
    word_go  = data_go && acc.xf == XF_WORD;
    seq_go   = data_go && acc.xf == XF_BYTE_SEQ;
    reg_wr   = wr_start && acc.hit && !is_dat;
    cmd_wr   = reg_wr && acc.off == 4'h7;
    srst_ev  = reg_wr && acc.off == 4'hE && wbyte[2];
    stat_rd  = rd_start && acc.hit && !is_dat && acc.off == 4'h7;
    ptr_clr  = cmd_wr || srst_ev;
    rd_ok    = acc.hit && (!is_dat || dat_ok);
    sel_byte = is_dat ? dat_byte : reg_byte;
    if (acc.xf == XF_WORD) rval = dat_word;
    else if (acc.lane_hi)  rval = {sel_byte, 8'h00};
    else                   rval = {8'h00, sel_byte};
  end

  tf_databuf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (data_go),
    .we    (wr_start),
    .xf    (acc.xf),
    .wword (d_in),
    .wbyte (wbyte),
    .clr   (ptr_clr),
    .ptr   (ptr),
    .rword (dat_word),
    .rbyte (dat_byte)
  );

  tf_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (reg_wr),
    .off      (acc.off),
    .wbyte    (wbyte),
    .drq      (drq),
    .stat_rd  (stat_rd),
    .srst     (srst_ev),
    .rbyte    (reg_byte),
    .intrq    (intrq),
    .features (cmd_features),
    .opcode   (cmd_opcode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q     <= 1'b1;
      wr_q     <= 1'b1;
      rd_act_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rd_q <= iord_n;
      wr_q <= iowr_n;
      if (rd_start) begin
        rd_act_q <= rd_ok;
        rdata_q  <= rval;
      end else if (iord_n) begin
        rd_act_q <= 1'b0;
      end
    end
  end

  assign d_oe  = rd_act_q && !iord_n;
  assign d_out = d_oe ? rdata_q : 16'h0000;

endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
  parameter int BUF_BYTES = 512,
  localparam int PW = $clog2(BUF_BYTES) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iord_n,
  input logic          d_oe,
  input logic          data_go,
  input logic          word_go,
  input logic          seq_go,
  input logic          cmd_wr,
  input logic          srst_ev,
  input logic          stat_rd,
  input logic [PW-1:0] ptr,
  input logic          intrq
);

  p_ptr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(BUF_BYTES));

  p_word_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_go |=> ptr == $past(ptr) + PW'(2));

  p_byte_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_go |=> (ptr == $past(ptr) + PW'(1)) || (ptr == $past(ptr) + PW'(2)));

  p_cmd_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> intrq && ptr == '0);

  p_stat_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !intrq);

  p_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_ev |=> !intrq && ptr == '0);

  p_oe_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !iord_n);

  p_ptr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_go || cmd_wr || srst_ev) |=> $stable(ptr));

endmodule

bind ata_taskfile_io ata_taskfile_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .iord_n  (iord_n),
  .d_oe    (d_oe),
  .data_go (data_go),
  .word_go (word_go),
  .seq_go  (seq_go),
  .cmd_wr  (cmd_wr),
  .srst_ev (srst_ev),
  .stat_rd (stat_rd),
  .ptr     (ptr),
  .intrq   (intrq)
);

// File: tb/sim_ata_taskfile_io.sv
module sim_ata_taskfile_io;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_sel_n = 1'b1;
  logic [3:0]  addr = 4'h0;
  logic        ce1_n = 1'b1, ce2_n = 1'b1;
  logic        iord_n = 1'b1, iowr_n = 1'b1;
  logic [15:0] d_in = 16'h0;
  logic [15:0] d_out;
  logic        d_oe, intrq;
  logic [7:0]  cmd_features, cmd_opcode;

  int nchk = 0, nerr = 0;
  bit done = 0;
  bit sel_off = 0;
  logic [7:0] m [512];

  always #5 clk = ~clk;

  ata_taskfile_io u0 (
    .clk(clk), .rst_n(rst_n), .io_sel_n(io_sel_n), .addr(addr),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .intrq(intrq),
    .cmd_features(cmd_features), .cmd_opcode(cmd_opcode)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 5 + 17) ^ (i >> 3));
  endfunction

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic c1, input logic c2,
                    output logic [15:0] v, output logic oe);
    @(negedge clk);
    io_sel_n = sel_off; addr = a; ce1_n = c1; ce2_n = c2; iord_n = 1'b0;
    @(negedge clk);
    v = d_out; oe = d_oe;
    iord_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1; io_sel_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic c1, input logic c2, input logic [15:0] v);
    @(negedge clk);
    io_sel_n = sel_off; addr = a; ce1_n = c1; ce2_n = c2; d_in = v; iowr_n = 1'b0;
    @(negedge clk);
    iowr_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1; io_sel_n = 1'b1;
  endtask

  task automatic new_cmd();
    wr(4'h7, 1'b0, 1'b1, 16'h0020);
  endtask

  task automatic t_reset();
    logic [15:0] v; logic oe;
    chk("R1 idle oe", {15'b0, d_oe}, 16'h0);
    chk("R1 intrq", {15'b0, intrq}, 16'h0);
    rd(4'h2, 1'b0, 1'b1, v, oe); chk("R1 sector count", v, 16'h0001);
    rd(4'h3, 1'b0, 1'b1, v, oe); chk("R1 sector number", v, 16'h0001);
    rd(4'h4, 1'b0, 1'b1, v, oe); chk("R1 cylinder low", v, 16'h0000);
    rd(4'h6, 1'b0, 1'b1, v, oe); chk("R1 card/head", v, 16'h0000);
    rd(4'h7, 1'b0, 1'b1, v, oe); chk("R1 status", v, 16'h0048);
  endtask

  task automatic t_fill_end();
    logic [15:0] v; logic oe;
    for (int i = 0; i < 256; i++) wr(4'h0, 1'b0, 1'b0, {m[2*i+1], m[2*i]});
    rd(4'h7, 1'b0, 1'b1, v, oe); chk("R10 status at end", v, 16'h0040);
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R10 read past end oe", {15'b0, oe}, 16'h0);
    wr(4'h0, 1'b0, 1'b0, 16'hDEAD);
    new_cmd();
    rd(4'h7, 1'b0, 1'b1, v, oe); chk("R10 status after cmd", v, 16'h0048);
    rd(4'h0, 1'b0, 1'b0, v, oe); chk("R10 word 0 untouched", v, {m[1], m[0]});
  endtask

  task automatic t_regs();
    logic [15:0] v; logic oe;
    wr(4'h2, 1'b0, 1'b1, 16'h0011);
    rd(4'h2, 1'b0, 1'b1, v, oe); chk("R2 sector count rw", v, 16'h0011);
    wr(4'h5, 1'b1, 1'b0, 16'hA500);
    rd(4'h5, 1'b0, 1'b1, v, oe); chk("R2 high lane write", v, 16'h00A5);
    rd(4'h4, 1'b1, 1'b0, v, oe); chk("R2 high lane read odd", v, 16'hA500);
  endtask

  task automatic t_word();
    logic [15:0] v; logic oe;
    new_cmd();
    rd(4'h0, 1'b0, 1'b0, v, oe); chk("R3 word at 0", v, {m[1], m[0]});
    rd(4'h8, 1'b0, 1'b0, v, oe); chk("R3 word at 8", v, {m[3], m[2]});
    rd(4'h9, 1'b0, 1'b0, v, oe); chk("R3 word at 9", v, {m[5], m[4]});
    rd(4'h1, 1'b0, 1'b0, v, oe); chk("R3 word at 1", v, {m[7], m[6]});
    new_cmd();
    wr(4'h9, 1'b0, 1'b0, 16'hBEEF); m[0] = 8'hEF; m[1] = 8'hBE;
    new_cmd();
    rd(4'h0, 1'b0, 1'b0, v, oe); chk("R3 word write", v, 16'hBEEF);
  endtask

  task automatic t_byte();
    logic [15:0] v; logic oe;
    new_cmd();
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R4 byte 0", v, {8'h00, m[0]});
    rd(4'h8, 1'b0, 1'b1, v, oe); chk("R4 byte 1", v, {8'h00, m[1]});
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R4 byte 2", v, {8'h00, m[2]});
    wr(4'h8, 1'b0, 1'b1, 16'h0012); m[3] = 8'h12;
    new_cmd();
    rd(4'h0, 1'b0, 1'b0, v, oe);
    rd(4'h0, 1'b0, 1'b0, v, oe); chk("R4 byte write", v, {m[3], m[2]});
  endtask

  task automatic t_errfeat();
    logic [15:0] v; logic oe;
    new_cmd();
    rd(4'h0, 1'b1, 1'b0, v, oe); chk("R5 error read", {v[15:1], oe}, 16'h0001);
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R5 pointer kept", v, {8'h00, m[0]});
    wr(4'h0, 1'b1, 1'b0, 16'h5A00);
    chk("R5 features", {8'h00, cmd_features}, 16'h005A);
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R5 pointer kept after write", v, {8'h00, m[1]});
  endtask

  task automatic t_odd();
    logic [15:0] v; logic oe;
    new_cmd();
    rd(4'h8, 1'b0, 1'b1, v, oe); chk("R6 8 then 9 even", v, {8'h00, m[0]});
    rd(4'h9, 1'b0, 1'b1, v, oe); chk("R6 8 then 9 odd", v, {8'h00, m[1]});
    rd(4'h9, 1'b0, 1'b1, v, oe); chk("R6 9 then 8 odd", v, {8'h00, m[3]});
    rd(4'h8, 1'b0, 1'b1, v, oe); chk("R6 9 then 8 even", v, {8'h00, m[2]});
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R6 next byte", v, {8'h00, m[4]});
  endtask

  task automatic t_misalign();
    logic [15:0] v; logic oe;
    new_cmd();
    rd(4'h0, 1'b0, 1'b1, v, oe);
    rd(4'h0, 1'b0, 1'b0, v, oe); chk("R7 odd word oe", {15'b0, oe}, 16'h0);
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R7 pointer kept", v, {8'h00, m[1]});
    rd(4'h0, 1'b0, 1'b0, v, oe); chk("R7 word realigned", v, {m[3], m[2]});
  endtask

  task automatic t_irq();
    logic [15:0] v; logic oe;
    new_cmd();
    chk("R8 intrq set", {15'b0, intrq}, 16'h1);
    chk("R8 opcode", {8'h00, cmd_opcode}, 16'h0020);
    rd(4'hE, 1'b0, 1'b1, v, oe); chk("R8 alt status", v, 16'h0048);
    chk("R8 alt keeps intrq", {15'b0, intrq}, 16'h1);
    rd(4'h7, 1'b0, 1'b1, v, oe); chk("R8 status", v, 16'h0048);
    chk("R8 status clears intrq", {15'b0, intrq}, 16'h0);
  endtask

  task automatic t_srst();
    logic [15:0] v; logic oe;
    new_cmd();
    rd(4'h0, 1'b0, 1'b1, v, oe);
    rd(4'h0, 1'b0, 1'b1, v, oe);
    wr(4'hE, 1'b0, 1'b1, 16'h0000);
    chk("R9 no srst keeps intrq", {15'b0, intrq}, 16'h1);
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R9 no srst keeps pointer", v, {8'h00, m[2]});
    wr(4'hE, 1'b0, 1'b1, 16'h0004);
    chk("R9 srst clears intrq", {15'b0, intrq}, 16'h0);
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R9 srst resets pointer", v, {8'h00, m[0]});
  endtask

  task automatic t_ignored();
    logic [15:0] v; logic oe;
    wr(4'h6, 1'b0, 1'b1, 16'h0005);
    sel_off = 1;
    rd(4'h6, 1'b0, 1'b1, v, oe); chk("R11 deselected oe", {15'b0, oe}, 16'h0);
    wr(4'h6, 1'b0, 1'b1, 16'h00FF);
    sel_off = 0;
    rd(4'h6, 1'b1, 1'b1, v, oe); chk("R11 no enable oe", {15'b0, oe}, 16'h0);
    rd(4'hB, 1'b0, 1'b1, v, oe); chk("R11 hole oe", {15'b0, oe}, 16'h0);
    wr(4'hF, 1'b0, 1'b1, 16'h0033);
    rd(4'h6, 1'b0, 1'b1, v, oe); chk("R11 card/head unchanged", v, 16'h0005);
    rd(4'hF, 1'b0, 1'b1, v, oe); chk("R11 drive address", v, 16'h00EA);
  endtask

  task automatic t_hold();
    logic [15:0] v; logic oe;
    new_cmd();
    @(negedge clk);
    io_sel_n = 0; addr = 4'h0; ce1_n = 0; ce2_n = 1; iord_n = 0;
    repeat (4) @(negedge clk);
    chk("R12 held read data", d_out, {8'h00, m[0]});
    iord_n = 1; ce1_n = 1; io_sel_n = 1;
    rd(4'h0, 1'b0, 1'b1, v, oe); chk("R12 one advance", v, {8'h00, m[1]});
    @(negedge clk);
    io_sel_n = 0; addr = 4'h2; ce1_n = 0; d_in = 16'h0077; iord_n = 0; iowr_n = 0;
    repeat (2) @(negedge clk);
    iord_n = 1; iowr_n = 1; ce1_n = 1; io_sel_n = 1;
    rd(4'h2, 1'b0, 1'b1, v, oe); chk("R12 both strobes ignored", v, 16'h0011);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) m[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_end();
    t_regs();
    t_word();
    t_byte();
    t_errfeat();
    t_odd();
    t_misalign();
    t_irq();
    t_srst();
    t_ignored();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule